// File: doc/BRIEF.md
# Streaming Byte Expansion Unit

This unit turns a packed byte stream into 16-byte vectors. Each input offers a 16-byte window that starts at the current read position, together with a 16-bit lane mask. Mask bit i controls output lane i.

The set bits take the next unread stream bytes. The lowest set lane gets window byte 0, the next set lane gets byte 1, and so on. Every lane whose bit is clear reads as zero. The unit also reports how many bytes it consumed, so the surrounding logic can move its read position forward by that amount.

The lane placement comes from two 8-bit half-mask decoders. Each decoder produces eight source indices and a set-bit count for its half. The upper half's indices are shifted by the lower half's count. The reported advance is the sum of the two counts. The result is registered, and it appears one clock after an accepted input. The window is assumed to be always fully readable, so no bounds check is made.

Top module: `byte_expand_unit`

## Requirements
- R1: Output lane i (bits [8i+7:8i] of `vec_o`) carries a stream byte only when `mask_i[i]` is 1. Every lane whose mask bit is 0 reads 0x00.
- R2: Set mask bits consume window bytes in ascending lane order: the k-th lowest set bit receives window byte k (bits [8k+7:8k] of `window_i`). Mask 0x0430 places byte 0 in lane 4, byte 1 in lane 5 and byte 2 in lane 10.
- R3: Lanes 8 to 15 take their bytes starting at an offset equal to the number of set bits in `mask_i[7:0]`. Mask 0xFF00 copies window bytes 0 to 7 into lanes 8 to 15. Mask 0x0101 puts window byte 1 into lane 8.
- R4: `adv_o` equals the number of set bits in the accepted mask, which ranges from 0 to 16.
- R5: An input accepted with `in_valid_i` high appears on `vec_o` and `adv_o` one clock later. `out_valid_o` is high in exactly the cycle after an accepted input.
- R6: An all-zero mask gives an all-zero vector and an advance of 0. An all-ones mask copies the window unchanged and gives an advance of 16.
- R7: In a cycle with `in_valid_i` low, `vec_o` and `adv_o` keep their previous values, and `out_valid_o` is low in the following cycle.
- R8: While `rst_ni` is low, `out_valid_o`, `vec_o` and `adv_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Window and mask are valid this cycle |
| window_i | input | 128 | 16 stream bytes from the read position; byte 0 in bits [7:0] |
| mask_i | input | 16 | Lane mask; bit i selects lane i |
| out_valid_o | output | 1 | Registered result is new this cycle |
| vec_o | output | 128 | Expanded vector; lane i in bits [8i+7:8i] |
| adv_o | output | 5 | Number of stream bytes consumed |

## Verification
The assertions assume that `window_i` and `mask_i` are sampled only when `in_valid_i` is high. They do not assume that the window holds meaningful stream data. They also assume that the mask can be any 16-bit value, including the all-zero and all-ones masks.

The stimulus reads each window from a random byte stream at a position that the reference model advances by its own count. Every window therefore lies inside the stream array, and the array wraps to the start long before it could run past its end. Idle cycles are mixed in so that the hold behaviour is exercised. Directed masks cover the empty, full, half and example patterns, and random masks cover the rest.

// File: rtl/bexp_pkg.sv
package bexp_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bexp_half_decode.sv
// Decodes one half of the lane mask into per-lane source indices and a set count.
module bexp_half_decode #(
    parameter int unsigned HALF  = 8,
    parameter int unsigned IDX_W = 4,
    localparam int unsigned CNT_H = $clog2(HALF + 1)
) (
    input  logic [HALF-1:0]            mask_i,
    output logic [HALF-1:0][IDX_W-1:0] idx_o,
    output logic [CNT_H-1:0]           cnt_o
);
    always_comb begin
        logic [CNT_H-1:0] run;
        run = '0;
        for (int i = 0; i < int'(HALF); i++) begin
            idx_o[i] = IDX_W'(run);
            if (mask_i[i]) begin
                run = run + CNT_H'(1);
            end
        end
        cnt_o = run;
    end
endmodule

// File: rtl/bexp_lane_select.sv
// Picks one window byte per lane, forcing cleared lanes to zero.
module bexp_lane_select
    import bexp_pkg::*;
#(
    parameter int unsigned LANES = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [LANES*BYTE_W-1:0]     window_i,
    input  logic [LANES-1:0]            mask_i,
    input  logic [LANES-1:0][IDX_W-1:0] idx_i,
    output logic [LANES*BYTE_W-1:0]     vec_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        byte_t pick;
        always_comb begin
            pick = window_i[int'(idx_i[l])*BYTE_W +: BYTE_W];
            vec_o[l*BYTE_W +: BYTE_W] = mask_i[l] ? pick : '0;
        end
    end
endmodule

// File: rtl/byte_expand_unit.sv
module byte_expand_unit
    import bexp_pkg::*;
#(
    parameter int unsigned LANES = 16,
    localparam int unsigned HALF  = LANES / 2,
    localparam int unsigned IDX_W = $clog2(LANES),
    localparam int unsigned CNT_W = $clog2(LANES + 1),
    localparam int unsigned CNT_H = $clog2(HALF + 1),
    localparam int unsigned VEC_W = LANES * BYTE_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             in_valid_i,
    input  logic [VEC_W-1:0] window_i,
    input  logic [LANES-1:0] mask_i,
    output logic             out_valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [CNT_W-1:0] adv_o
);
    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] vec;
        logic [CNT_W-1:0] adv;
    } state_t;

    state_t state_d, state_q;

    logic [1:0][HALF-1:0][IDX_W-1:0] half_idx;
    logic [1:0][CNT_H-1:0]           half_cnt;
    logic [LANES-1:0][IDX_W-1:0]     lane_idx;
    logic [VEC_W-1:0]                expanded;

    for (genvar h = 0; h < 2; h++) begin : g_half
        bexp_half_decode #(.HALF(HALF), .IDX_W(IDX_W)) i_dec (
            .mask_i (mask_i[h*HALF +: HALF]),
            .idx_o  (half_idx[h]),
            .cnt_o  (half_cnt[h])
        );
        for (genvar j = 0; j < HALF; j++) begin : g_off
            if (h == 0) begin : g_lo
                assign lane_idx[j] = half_idx[0][j];
            end else begin : g_hi
                assign lane_idx[HALF + j] = half_idx[1][j] + IDX_W'(half_cnt[0]);
            end
        end
    end

    bexp_lane_select #(.LANES(LANES), .IDX_W(IDX_W)) i_sel (
        .window_i (window_i),
        .mask_i   (mask_i),
        .idx_i    (lane_idx),
        .vec_o    (expanded)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid_i;
        if (in_valid_i) begin
            state_d.vec = expanded;
            state_d.adv = CNT_W'(half_cnt[0]) + CNT_W'(half_cnt[1]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid_o = state_q.vld;
    assign vec_o       = state_q.vec;
    assign adv_o       = state_q.adv;
endmodule

// File: rtl/byte_expand_unit_chk.sv
module byte_expand_unit_chk #(
    parameter int unsigned LANES = 16,
    parameter int unsigned VEC_W = 128,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             in_valid_i,
    input logic [VEC_W-1:0] window_i,
    input logic [LANES-1:0] mask_i,
    input logic             out_valid_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [CNT_W-1:0] adv_o
);
    a_r5_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);

    a_r7_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);

    a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> ($stable(vec_o) && $stable(adv_o)));

    a_r4_adv_popcount: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> (int'(adv_o) == $countones($past(mask_i))));

    a_r6_full_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (&mask_i)) |=> (vec_o == $past(window_i)));

    a_r2_first_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && mask_i[0]) |=> (vec_o[7:0] == $past(window_i[7:0])));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        a_r1_clear_lane_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (in_valid_i && !mask_i[l]) |=> (vec_o[l*8 +: 8] == 8'h00));
    end
endmodule

bind byte_expand_unit byte_expand_unit_chk #(
    .LANES(LANES), .VEC_W(VEC_W), .CNT_W(CNT_W)
) i_chk (.*);

// File: tb/test_byte_expand_unit.sv
module test_byte_expand_unit;
    localparam int STREAM_LEN = 4096;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] window = '0;
    logic [15:0]  mask = '0;
    logic         out_valid;
    logic [127:0] vec;
    logic [4:0]   adv;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]   stream [STREAM_LEN];
    int           pos = 0;
    logic [127:0] last_vec = '0;
    logic [4:0]   last_adv = '0;

    always #2 clk = ~clk;

    byte_expand_unit i_byte_expand_unit (
        .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .window_i(window),
        .mask_i(mask), .out_valid_o(out_valid), .vec_o(vec), .adv_o(adv)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural expansion: pop bytes from a queue into the set lanes, in order.
    task automatic model(input logic [127:0] win, input logic [15:0] m,
                         output logic [127:0] ev, output logic [4:0] ea);
        logic [7:0] q[$];
        int n = 0;
        for (int k = 0; k < 16; k++) q.push_back(win[k*8 +: 8]);
        ev = '0;
        for (int l = 0; l < 16; l++) begin
            if (m[l]) begin
                ev[l*8 +: 8] = q.pop_front();
                n++;
            end
        end
        ea = 5'(n);
    endtask

    task automatic step(input bit v, input logic [15:0] m, input string tag);
        logic [127:0] ev;
        logic [4:0]   ea;
        @(negedge clk);
        if (pos > STREAM_LEN - 40) pos = 0;
        for (int k = 0; k < 16; k++) window[k*8 +: 8] = stream[pos + k];
        in_valid = v;
        mask = m;
        model(window, m, ev, ea);
        @(negedge clk);
        in_valid = 1'b0;
        if (v) begin
            chk({"R5 valid ", tag}, 128'(out_valid), 128'(1'b1));
            chk({"R1/R2/R3 vector ", tag}, vec, ev);
            chk({"R4 advance ", tag}, 128'(adv), 128'(ea));
            last_vec = ev;
            last_adv = ea;
            pos += int'(ea);
        end else begin
            chk({"R7 idle valid ", tag}, 128'(out_valid), 128'(1'b0));
            chk({"R7 idle vector hold ", tag}, vec, last_vec);
            chk({"R7 idle advance hold ", tag}, 128'(adv), 128'(last_adv));
        end
    endtask

    initial begin
        for (int i = 0; i < STREAM_LEN; i++) stream[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        chk("R8 reset valid", 128'(out_valid), 128'(1'b0));
        chk("R8 reset vector", vec, '0);
        chk("R8 reset advance", 128'(adv), '0);
        @(negedge clk);
        rst_n = 1'b1;

        step(1'b1, 16'h0000, "R6 empty mask");
        step(1'b1, 16'hFFFF, "R6 full mask");
        step(1'b1, 16'h0430, "R2 example");
        step(1'b1, 16'hFF00, "R3 upper only");
        step(1'b1, 16'h0101, "R3 offset one");
        step(1'b1, 16'h00FF, "R3 lower only");
        step(1'b1, 16'h8001, "R1 ends");
        step(1'b0, 16'hFFFF, "R7 idle");
        step(1'b0, 16'h1234, "R7 idle again");
        for (int b = 0; b < 16; b++) step(1'b1, 16'(1) << b, "R1 walking");
        for (int i = 0; i < 300; i++)
            step(($urandom % 5) != 0, 16'($urandom), "R2 random");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule